// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of general-purpose pins that software drives through a simple register port. Each pin can be set as an input or an output. It can also drive a level when it is an output, and its pad level can be read back through a two-flop synchroniser. The pin count is a parameter of up to 64. Every register kind therefore takes two 32-bit words: the low word holds pins 0 to 31, and the word 4 bytes higher holds pins 32 and up, at bit position pin minus 32.

Each pin also has a single-edge detector. A per-pin polarity bit chooses between a rising and a falling transition on the synchronised level. A matching transition sets a sticky status bit, and software clears that bit by writing a one to it. One interrupt line leaves the block. It is the registered OR of every status bit whose enable bit is set. A separate per-pin mask marks which pins may wake the system and goes out on its own port.

The register port is a single-cycle strobe. Writes take effect at the clock edge on which they are presented. Read data is valid in the same cycle as the read strobe.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output enable, output level, interrupt enable, polarity, status and wake masks all read as zero; `pad_oe`, `pad_out`, `wake_mask` and `irq` are low.
- R2: Output enable is at 0x00 and output level at 0x18. The high word of each is at +0x04. A 1 in output enable drives the pin from the output level register, and `pad_oe`/`pad_out` follow the stored bits.
- R3: The input value word (0x10 low, 0x14 high) returns the pad level after two register stages. A pad change made before clock edge k is visible after edge k+1, but not after edge k.
- R4: Interrupt enable is at 0x40, polarity at 0x48, status at 0x50 and wake mask at 0x58. Each has its high word at +0x04.
- R5: A polarity bit of 0 latches status on a 0-to-1 change of the synchronised level, and a polarity bit of 1 latches it on a 1-to-0 change. The opposite change leaves status unchanged.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it as it was.
- R7: Status latches whether or not the pin's interrupt enable is set. A pending bit on a disabled pin does not raise `irq`.
- R8: `irq` rises one edge after an enabled status bit becomes set, in either word. It falls one edge after the last enabled pending bit clears.
- R9: If an edge is detected on a pin in the same cycle that software writes 1 to its status bit, the bit stays set.
- R10: Bits for pins at or above the configured pin count read as zero, and writes to them are discarded.
- R11: The `wake_mask` output follows the wake mask register bit for bit.
- R12: Any read of an address outside the listed registers returns zero, and a write to one changes no register. This includes 0x08, 0x20 and any address whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 7 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is strobed |
| pad_in | input | NPINS | Raw pad levels (asynchronous) |
| pad_out | output | NPINS | Level driven on each pin |
| pad_oe | output | NPINS | Output enable for each pin |
| wake_mask | output | NPINS | Pins marked as wake-up sources |
| irq | output | 1 | Aggregated interrupt |

## Verification
The two functions that can fall in the same cycle are a freshly detected edge setting a status bit and a software write-one that clears the same bit. The bench arranges this by changing the pad, counting the two synchroniser edges, and then presenting the clearing write so that it is captured on the very edge where the detector fires. It then reads status back and expects the bit still set. A following write-one with no edge present must clear the bit, which shows the clear itself works.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WORD_W = 32;
  localparam int WIDE_W = 2 * WORD_W;

  // slot numbers of the plain read/write configuration words
  localparam logic [2:0] SLOT_OE   = 3'd0;
  localparam logic [2:0] SLOT_OUT  = 3'd1;
  localparam logic [2:0] SLOT_EN   = 3'd2;
  localparam logic [2:0] SLOT_POL  = 3'd3;
  localparam logic [2:0] SLOT_WAKE = 3'd4;
  localparam logic [2:0] SLOT_NONE = 3'd7;
  localparam int         NSLOTS    = 5;

  // kind field (address bits 4:3) inside each block
  localparam logic [1:0] KIND_LEVEL  = 2'd2;  // data block: input level
  localparam logic [1:0] KIND_STATUS = 2'd2;  // interrupt block: status

  function automatic logic [2:0] slot_of(input logic irq_blk, input logic [1:0] kind);
    logic [2:0] s;
    s = SLOT_NONE;
    if (!irq_blk) begin
      if (kind == 2'd0) s = SLOT_OE;
      if (kind == 2'd3) s = SLOT_OUT;
    end else begin
      if (kind == 2'd0) s = SLOT_EN;
      if (kind == 2'd1) s = SLOT_POL;
      if (kind == 2'd3) s = SLOT_WAKE;
    end
    return s;
  endfunction

  function automatic logic [WIDE_W-1:0] put_word(input logic [WIDE_W-1:0] old,
                                                 input logic [WORD_W-1:0] wd,
                                                 input logic hi);
    logic [WIDE_W-1:0] r;
    r = old;
    if (hi) r[WIDE_W-1:WORD_W] = wd;
    else    r[WORD_W-1:0]      = wd;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] get_word(input logic [WIDE_W-1:0] v, input logic hi);
    return hi ? v[WIDE_W-1:WORD_W] : v[WORD_W-1:0];
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o
);
  logic [N-1:0] meta_q, lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= raw_i;
      lvl_q  <= meta_q;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int N = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] prev_q, stat_q, stat_d, hit;
  logic         irq_q, irq_d;

  always_comb begin
    // a change of level whose new value differs from the polarity bit
    hit    = (lvl_i ^ prev_q) & (lvl_i ^ pol_i);
    stat_d = (stat_q & ~clr_i) | hit;
    irq_d  = |(stat_q & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = irq_q;

  // R6: a set bit only drops when a one was written to it
  assert_w1c_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_i) & ~stat_q) == '0));

  // R9: a detected edge always leaves its bit set, clear or not
  assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((stat_q & $past(hit)) == $past(hit)));

  // R5: no bit becomes set without a level change on its pin
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~($past(lvl_i) ^ $past(prev_q))) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [6:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  wake_mask,
  output logic              irq
);
  // reset: asserted at once, released after two edges
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  // address decode
  logic       addr_ok, irq_blk, word_hi, do_wr, do_rd;
  logic [1:0] kind;
  logic [2:0] slot;

  always_comb begin
    irq_blk = bus_addr[6];
    kind    = bus_addr[4:3];
    word_hi = bus_addr[2];
    addr_ok = bus_en && (bus_addr[1:0] == 2'b00) && !bus_addr[5];
    do_wr   = addr_ok && bus_we;
    do_rd   = addr_ok && !bus_we;
    slot    = slot_of(irq_blk, kind);
  end

  // plain configuration words
  logic [NPINS-1:0] cfg_q [NSLOTS];

  for (genvar i = 0; i < NSLOTS; i++) begin : g_cfg
    logic [NPINS-1:0]  q, d;
    logic [WIDE_W-1:0] merged;
    logic              we;

    always_comb begin
      we     = do_wr && (slot == 3'(i));
      merged = put_word(WIDE_W'(q), bus_wdata, word_hi);
      d      = merged[NPINS-1:0];
    end

    always_ff @(posedge clk or negedge rs_n) begin
      if (!rs_n)   q <= '0;
      else if (we) q <= d;
    end

    assign cfg_q[i] = q;
  end

  // synchroniser and edge/interrupt logic
  logic [NPINS-1:0]  lvl, status, clr;
  logic [WIDE_W-1:0] clr_wide;

  always_comb begin
    clr_wide = '0;
    if (do_wr && irq_blk && (kind == KIND_STATUS))
      clr_wide = put_word('0, bus_wdata, word_hi);
    clr = clr_wide[NPINS-1:0];
  end

  gpio_sync #(.N(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rs_n),
    .raw_i (pad_in),
    .lvl_o (lvl)
  );

  gpio_edge_irq #(.N(NPINS)) u_edge (
    .clk      (clk),
    .rst_n    (rs_n),
    .lvl_i    (lvl),
    .pol_i    (cfg_q[SLOT_POL]),
    .en_i     (cfg_q[SLOT_EN]),
    .clr_i    (clr),
    .status_o (status),
    .irq_o    (irq)
  );

  // read path
  logic [WIDE_W-1:0] rd_wide;
  always_comb begin
    rd_wide = '0;
    if (do_rd) begin
      case (slot)
        SLOT_OE:   rd_wide = WIDE_W'(cfg_q[SLOT_OE]);
        SLOT_OUT:  rd_wide = WIDE_W'(cfg_q[SLOT_OUT]);
        SLOT_EN:   rd_wide = WIDE_W'(cfg_q[SLOT_EN]);
        SLOT_POL:  rd_wide = WIDE_W'(cfg_q[SLOT_POL]);
        SLOT_WAKE: rd_wide = WIDE_W'(cfg_q[SLOT_WAKE]);
        default: begin
          if (kind == KIND_LEVEL) rd_wide = irq_blk ? WIDE_W'(status) : WIDE_W'(lvl);
        end
      endcase
    end
    bus_rdata = get_word(rd_wide, word_hi);
  end

  assign pad_oe    = cfg_q[SLOT_OE];
  assign pad_out   = cfg_q[SLOT_OUT];
  assign wake_mask = cfg_q[SLOT_WAKE];

  // R2: the pin direction moves only on a register write
  assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rs_n)
    !(bus_en && bus_we) |=> $stable(pad_oe));

  // R11: the wake mask moves only on a register write
  assert_wake_hold_R11: assert property (@(posedge clk) disable iff (!rs_n)
    !(bus_en && bus_we) |=> $stable(wake_mask));

  // R8: the interrupt line rises only after an enabled pending bit existed
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(irq) |-> $past(|(status & cfg_q[SLOT_EN])));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int NP = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_en, bus_we;
  logic [6:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe, wake_mask;
  logic          irq;

  always #5 clk = ~clk;

  gpio_bank #(.NPINS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .wake_mask(wake_mask), .irq(irq)
  );

  localparam logic [6:0] A_OE = 7'h00, A_IN = 7'h10, A_OUT = 7'h18;
  localparam logic [6:0] A_EN = 7'h40, A_POL = 7'h48, A_ST = 7'h50, A_WK = 7'h58;

  int total = 0, fails = 0;
  logic [31:0] rv;

  // {address, write data, expected read-back}
  localparam int NV = 13;
  localparam logic [70:0] VEC [NV] = '{
    {7'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {7'h04, 32'hFFFF_FFFF, 32'h0000_000F},
    {7'h18, 32'h1234_5678, 32'h1234_5678},
    {7'h1C, 32'h0000_0009, 32'h0000_0009},
    {7'h40, 32'h8000_0001, 32'h8000_0001},
    {7'h44, 32'hFFFF_FFF3, 32'h0000_0003},
    {7'h48, 32'h0000_00F0, 32'h0000_00F0},
    {7'h4C, 32'h0000_000C, 32'h0000_000C},
    {7'h58, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {7'h5C, 32'h0000_0005, 32'h0000_0005},
    {7'h20, 32'hFFFF_FFFF, 32'h0000_0000},
    {7'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    {7'h10, 32'hFFFF_FFFF, 32'h0000_0000}
  };
  localparam string VTAG [NV] = '{"R2", "R10", "R2", "R2", "R4", "R10", "R4",
                                 "R4", "R4", "R4", "R12", "R12", "R3"};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    @(negedge clk);
    do_reset();

    // R1: reset state
    rd(A_OE, rv);  check("R1 oe", rv, 0);
    rd(A_ST, rv);  check("R1 status", rv, 0);
    check("R1 irq", irq, 0);
    check("R1 pad_oe", pad_oe, 0);

    // table: write then read back each word
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][70:64], VEC[i][63:32]);
      rd(VEC[i][70:64], rv);
      check(VTAG[i], rv, VEC[i][31:0]);
    end
    check("R2 pad_oe", pad_oe, {4'hF, 32'hA5A5_0F0F});
    check("R2 pad_out", pad_out, {4'h9, 32'h1234_5678});
    check("R11 wake_mask", wake_mask, {4'h5, 32'hDEAD_BEEF});
    rd(7'h42, rv); check("R12 misaligned", rv, 0);

    // R1: a second reset clears everything written above
    do_reset();
    rd(A_OE + 7'h4, rv); check("R1 oe high", rv, 0);
    rd(A_WK, rv);        check("R1 wake", rv, 0);
    rd(A_EN, rv);        check("R1 enable", rv, 0);
    rd(A_POL + 7'h4, rv); check("R1 polarity high", rv, 0);
    check("R1 pad_out", pad_out, 0);

    // R3: two-stage input path
    pad_in[5] = 1'b1;
    rd(A_IN, rv); check("R3 before edge", rv, 0);
    @(negedge clk);
    rd(A_IN, rv); check("R3 one stage", rv, 0);
    @(negedge clk);
    rd(A_IN, rv); check("R3 two stages", rv, 32'h20);
    // R5/R7: rising edge latched on a disabled pin, no irq
    @(negedge clk);
    rd(A_ST, rv); check("R5 rising latched", rv, 32'h20);
    idle(2);
    check("R7 disabled no irq", irq, 0);

    // R6: write zero keeps, write one clears
    wr(A_ST, 32'h0);  rd(A_ST, rv); check("R6 write zero", rv, 32'h20);
    wr(A_ST, 32'h20); rd(A_ST, rv); check("R6 write one", rv, 0);

    // R5: falling ignored at polarity 0, then falling detected at polarity 1
    pad_in[5] = 1'b0; idle(4);
    rd(A_ST, rv); check("R5 fall ignored", rv, 0);
    wr(A_POL, 32'h20);
    pad_in[5] = 1'b1; idle(4);
    rd(A_ST, rv); check("R5 rise ignored", rv, 0);
    pad_in[5] = 1'b0; idle(4);
    rd(A_ST, rv); check("R5 fall latched", rv, 32'h20);
    wr(A_ST, 32'h20);

    // R8: high-word pin 33 enabled, irq one edge after status
    wr(A_EN + 7'h4, 32'h2);
    pad_in[33] = 1'b1;
    idle(3);
    check("R8 irq not yet", irq, 0);
    @(negedge clk);
    check("R8 irq raised", irq, 1);
    rd(A_ST + 7'h4, rv); check("R8 status high", rv, 32'h2);
    wr(A_ST + 7'h4, 32'h2);
    check("R8 irq lags clear", irq, 1);
    @(negedge clk);
    check("R8 irq dropped", irq, 0);

    // R9: edge and clear meet on the same edge
    pad_in[0] = 1'b1; idle(4);
    rd(A_ST, rv); check("R9 setup", rv, 32'h1);
    pad_in[0] = 1'b0; idle(4);
    pad_in[0] = 1'b1;
    idle(2);
    wr(A_ST, 32'h1);
    rd(A_ST, rv); check("R9 edge wins", rv, 32'h1);
    wr(A_ST, 32'h1);
    rd(A_ST, rv); check("R9 plain clear", rv, 0);

    // R10: unimplemented high bits
    wr(A_WK + 7'h4, 32'hFFFF_FFFF);
    rd(A_WK + 7'h4, rv); check("R10 wake high", rv, 32'hF);
    check("R11 wake port", wake_mask, {4'hF, 32'h0});

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule